// File: doc/BRIEF.md
# Multiplexed External Memory Bus Bridge

This block connects the data-memory port of a small 8-bit processor to an external memory. The external bus shares one 8-bit port between the low address byte and the data. A second port carries the high address byte. Three control pins complete the bus: an address-latch enable (ALE) and active-low read and write strobes. An external transparent latch, opened while ALE is high, keeps the low address byte for the memory. The block compares each access address with a parameterised internal boundary. Addresses at or below the boundary go to an on-block internal RAM. Addresses above it go out on the bus.

A single enable input decides who owns the pins. With the enable set, the bridge drives the pin values and output enables, whatever the normal port settings say. Every access, internal ones included, then shows an address phase on the pins. The strobes move only for external addresses. With the enable clear, the normal port values pass straight through. Internal accesses then finish in one cycle, and addresses above the boundary reach nothing. The processor side uses a hold-until-ready handshake with no wait states: five cycles per access when enabled, two when disabled.

Top module: `muxbus_bridge`

## Requirements
- R1: An access whose address is greater than INT_TOP (default 0x00FF) is external. Any other access is internal. Only external accesses may pull the RD or WR strobe low.
- R2: The acceptance edge is the rising edge at which the block is idle, no ready pulse is showing and `cpu_req` is high. With the interface enabled, cycle 1 after that edge has ALE high, AD driven (all output enables set) with address bits [7:0], and the high port driven with address bits [15:8].
- R3: In cycle 2, ALE is low, AD still carries address bits [7:0] with its enables set, and both strobes are high. ALE stays low until the next access.
- R4: On a write, cycle 3 drives the write data on AD with WR still high. Cycle 4 keeps the same data and holds WR low for exactly that one cycle.
- R5: On an external read, AD is released (all enables clear) in cycles 3 and 4, and RD is low in cycle 4 only. The value on `pad_ad_i` at the end of cycle 4 is returned on `cpu_rdata`.
- R6: RD and WR are active-low, are never low together, and are high outside cycle 4 of an access.
- R7: An internal access while enabled shows the same ALE and address phases. In cycles 3 and 4 it drives the write data, or for a read the internal RAM content. RD and WR stay high, and the internal RAM serves the access.
- R8: While enabled, the pins take their values from the bridge. The high-byte and control enables are all ones, and the `gpio_*` inputs are ignored. While disabled, every pin value and enable equals its `gpio_*` input. Control bit order: [0] ALE, [1] RD, [2] WR.
- R9: `cfg_en` is sampled only on idle edges. An access finishes in the mode sampled at its acceptance, even if `cfg_en` changes while it runs.
- R10: While disabled, an access above INT_TOP writes nothing to the internal RAM (no aliasing). A read of such an address returns 0x00, and the bus shows no activity.
- R11: `cpu_ready` is a one-cycle pulse, in cycle 5 when enabled and in cycle 2 when disabled. `cpu_rdata` is valid in that cycle. No request is accepted during the ready cycle.
- R12: During reset, `cpu_ready` and `cpu_rdata` are zero and the pins follow the `gpio_*` inputs, whatever the value of `cfg_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Interface enable, sampled when idle |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| gpio_ad_out | input | 8 | Normal value for the AD pins |
| gpio_ad_oe | input | 8 | Normal direction for the AD pins |
| gpio_hi_out | input | 8 | Normal value for the high-address pins |
| gpio_hi_oe | input | 8 | Normal direction for the high-address pins |
| gpio_ctl_out | input | 3 | Normal value for the ALE/RD/WR pins |
| gpio_ctl_oe | input | 3 | Normal direction for the ALE/RD/WR pins |
| pad_ad_o | output | 8 | AD pin output value |
| pad_ad_oe | output | 8 | AD pin output enable per bit |
| pad_ad_i | input | 8 | AD pin input value |
| pad_hi_o | output | 8 | High-address pin output value |
| pad_hi_oe | output | 8 | High-address pin output enable |
| pad_ale | output | 1 | ALE pin value |
| pad_rd_n | output | 1 | Read strobe pin value, active low |
| pad_wr_n | output | 1 | Write strobe pin value, active low |
| pad_ctl_oe | output | 3 | Output enables for ALE, RD, WR |

## Verification
Two functions can meet in one cycle: a change of the enable, which takes the pins away from the bridge, and an access that is still running. The bench flips `cfg_en` and rewrites the `gpio_*` values in cycle 2 of an access. It then checks at the pins that the access still finishes its strobe and data phases in its original mode. It also checks that the new mode appears only once the block is idle. Sweeps across the boundary in both modes check the other case, where the external read and write paths meet the no-alias rule.

// File: rtl/muxbus_pkg.sv
// Shared types for the multiplexed bus bridge.
// Assumes: one access in flight at a time.
package muxbus_pkg;

    // Access sequencer states; ST_LOCAL is the single-cycle path used while disabled.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_LATCH,
        ST_TURN,
        ST_STROBE,
        ST_LOCAL
    } bus_state_t;

endpackage

// File: rtl/muxbus_iram.sv
// Internal data RAM reached for addresses at or below the boundary.
// Assumes: asynchronous read, synchronous write; contents are not reset.
module muxbus_iram #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte per write cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the addressed byte without delay.
    assign rdata = mem[addr];

endmodule

// File: rtl/muxbus_seq.sv
// Access sequencer: accepts a processor request, samples the enable while idle,
// decodes internal/external and produces the ALE, strobe and AD drive pattern.
// Assumes: requester holds cpu_req and its operands stable until cpu_ready.
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter int unsigned INT_TOP = 255,
    parameter int          IRAM_AW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_en,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_ready,
    output logic                     en_q,
    output logic                     bus_ale,
    output logic                     bus_rd_n,
    output logic                     bus_wr_n,
    output logic [DATA_W-1:0]        bus_ad_o,
    output logic                     bus_ad_oe,
    output logic [ADDR_W-DATA_W-1:0] bus_hi_o,
    input  logic [DATA_W-1:0]        bus_ad_i,
    output logic                     iram_we,
    output logic [IRAM_AW-1:0]       iram_addr,
    output logic [DATA_W-1:0]        iram_wdata,
    input  logic [DATA_W-1:0]        iram_rdata
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(INT_TOP);

    bus_state_t        state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic              ext_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ready_q;
    logic              data_phase;

    // Sequence state, captured operands, sampled enable and returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            en_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            ext_q   <= 1'b0;
            rdata_q <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    en_q <= cfg_en;
                    if (cpu_req && !ready_q) begin
                        addr_q  <= cpu_addr;
                        wdata_q <= cpu_wdata;
                        we_q    <= cpu_we;
                        ext_q   <= (cpu_addr > TOP_ADDR);
                        state   <= cfg_en ? ST_ALE : ST_LOCAL;
                    end
                end
                ST_ALE:   state <= ST_LATCH;
                ST_LATCH: state <= ST_TURN;
                ST_TURN:  state <= ST_STROBE;
                ST_STROBE: begin
                    if (!we_q) begin
                        rdata_q <= ext_q ? bus_ad_i : iram_rdata;
                    end
                    ready_q <= 1'b1;
                    state   <= ST_IDLE;
                end
                ST_LOCAL: begin
                    if (!we_q) begin
                        rdata_q <= ext_q ? '0 : iram_rdata;
                    end
                    ready_q <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus pattern decoded from the current phase.
    always_comb begin
        data_phase = (state == ST_TURN) || (state == ST_STROBE);
        bus_ale    = (state == ST_ALE);
        bus_wr_n   = !((state == ST_STROBE) && we_q && ext_q);
        bus_rd_n   = !((state == ST_STROBE) && !we_q && ext_q);
        bus_ad_o   = '0;
        bus_ad_oe  = 1'b0;
        if ((state == ST_ALE) || (state == ST_LATCH)) begin
            bus_ad_o  = addr_q[DATA_W-1:0];
            bus_ad_oe = 1'b1;
        end else if (data_phase) begin
            bus_ad_o  = we_q ? wdata_q : (ext_q ? '0 : iram_rdata);
            bus_ad_oe = we_q || !ext_q;
        end
    end

    assign bus_hi_o   = addr_q[ADDR_W-1:DATA_W];
    assign iram_we    = ((state == ST_STROBE) || (state == ST_LOCAL)) && we_q && !ext_q;
    assign iram_addr  = addr_q[IRAM_AW-1:0];
    assign iram_wdata = wdata_q;
    assign cpu_rdata  = rdata_q;
    assign cpu_ready  = ready_q;

endmodule

// File: rtl/muxbus_pinmux.sv
// Pin ownership: the bridge owns the bus pins while enabled, the normal port
// settings pass through otherwise. Assumes en is stable within an access.
module muxbus_pinmux #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     en,
    input  logic                     bus_ale,
    input  logic                     bus_rd_n,
    input  logic                     bus_wr_n,
    input  logic [DATA_W-1:0]        bus_ad_o,
    input  logic                     bus_ad_oe,
    input  logic [ADDR_W-DATA_W-1:0] bus_hi_o,
    input  logic [DATA_W-1:0]        gpio_ad_out,
    input  logic [DATA_W-1:0]        gpio_ad_oe,
    input  logic [ADDR_W-DATA_W-1:0] gpio_hi_out,
    input  logic [ADDR_W-DATA_W-1:0] gpio_hi_oe,
    input  logic [2:0]               gpio_ctl_out,
    input  logic [2:0]               gpio_ctl_oe,
    output logic [DATA_W-1:0]        pad_ad_o,
    output logic [DATA_W-1:0]        pad_ad_oe,
    output logic [ADDR_W-DATA_W-1:0] pad_hi_o,
    output logic [ADDR_W-DATA_W-1:0] pad_hi_oe,
    output logic                     pad_ale,
    output logic                     pad_rd_n,
    output logic                     pad_wr_n,
    output logic [2:0]               pad_ctl_oe
);

    // Per-bit selection on the shared address/data port.
    for (genvar i = 0; i < DATA_W; i++) begin : g_ad
        assign pad_ad_o[i]  = en ? bus_ad_o[i] : gpio_ad_out[i];
        assign pad_ad_oe[i] = en ? bus_ad_oe   : gpio_ad_oe[i];
    end

    // High address byte and control pins.
    assign pad_hi_o   = en ? bus_hi_o : gpio_hi_out;
    assign pad_hi_oe  = en ? '1       : gpio_hi_oe;
    assign pad_ale    = en ? bus_ale  : gpio_ctl_out[0];
    assign pad_rd_n   = en ? bus_rd_n : gpio_ctl_out[1];
    assign pad_wr_n   = en ? bus_wr_n : gpio_ctl_out[2];
    assign pad_ctl_oe = en ? 3'b111   : gpio_ctl_oe;

endmodule

// File: rtl/muxbus_bridge.sv
// Top of the multiplexed external memory bus bridge: sequencer, internal RAM
// and pin ownership mux. Assumes a single requester with hold-until-ready.
module muxbus_bridge #(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter int unsigned INT_TOP = 255
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_en,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_ready,
    input  logic [DATA_W-1:0]        gpio_ad_out,
    input  logic [DATA_W-1:0]        gpio_ad_oe,
    input  logic [ADDR_W-DATA_W-1:0] gpio_hi_out,
    input  logic [ADDR_W-DATA_W-1:0] gpio_hi_oe,
    input  logic [2:0]               gpio_ctl_out,
    input  logic [2:0]               gpio_ctl_oe,
    output logic [DATA_W-1:0]        pad_ad_o,
    output logic [DATA_W-1:0]        pad_ad_oe,
    input  logic [DATA_W-1:0]        pad_ad_i,
    output logic [ADDR_W-DATA_W-1:0] pad_hi_o,
    output logic [ADDR_W-DATA_W-1:0] pad_hi_oe,
    output logic                     pad_ale,
    output logic                     pad_rd_n,
    output logic                     pad_wr_n,
    output logic [2:0]               pad_ctl_oe
);

    localparam int IRAM_DEPTH = int'(INT_TOP) + 1;
    localparam int IRAM_AW    = (IRAM_DEPTH > 1) ? $clog2(IRAM_DEPTH) : 1;

    logic                     en_q;
    logic                     bus_ale;
    logic                     bus_rd_n;
    logic                     bus_wr_n;
    logic [DATA_W-1:0]        bus_ad_o;
    logic                     bus_ad_oe;
    logic [ADDR_W-DATA_W-1:0] bus_hi_o;
    logic                     iram_we;
    logic [IRAM_AW-1:0]       iram_addr;
    logic [DATA_W-1:0]        iram_wdata;
    logic [DATA_W-1:0]        iram_rdata;

    muxbus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .INT_TOP(INT_TOP),
        .IRAM_AW(IRAM_AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .en_q      (en_q),
        .bus_ale   (bus_ale),
        .bus_rd_n  (bus_rd_n),
        .bus_wr_n  (bus_wr_n),
        .bus_ad_o  (bus_ad_o),
        .bus_ad_oe (bus_ad_oe),
        .bus_hi_o  (bus_hi_o),
        .bus_ad_i  (pad_ad_i),
        .iram_we   (iram_we),
        .iram_addr (iram_addr),
        .iram_wdata(iram_wdata),
        .iram_rdata(iram_rdata)
    );

    muxbus_iram #(
        .DEPTH (IRAM_DEPTH),
        .DATA_W(DATA_W),
        .AW    (IRAM_AW)
    ) u_iram (
        .clk  (clk),
        .we   (iram_we),
        .addr (iram_addr),
        .wdata(iram_wdata),
        .rdata(iram_rdata)
    );

    muxbus_pinmux #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pinmux (
        .en          (en_q),
        .bus_ale     (bus_ale),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n),
        .bus_ad_o    (bus_ad_o),
        .bus_ad_oe   (bus_ad_oe),
        .bus_hi_o    (bus_hi_o),
        .gpio_ad_out (gpio_ad_out),
        .gpio_ad_oe  (gpio_ad_oe),
        .gpio_hi_out (gpio_hi_out),
        .gpio_hi_oe  (gpio_hi_oe),
        .gpio_ctl_out(gpio_ctl_out),
        .gpio_ctl_oe (gpio_ctl_oe),
        .pad_ad_o    (pad_ad_o),
        .pad_ad_oe   (pad_ad_oe),
        .pad_hi_o    (pad_hi_o),
        .pad_hi_oe   (pad_hi_oe),
        .pad_ale     (pad_ale),
        .pad_rd_n    (pad_rd_n),
        .pad_wr_n    (pad_wr_n),
        .pad_ctl_oe  (pad_ctl_oe)
    );

endmodule

// File: rtl/muxbus_bridge_chk.sv
// Protocol checker bound to the bridge: watches the sequencer's bus pattern
// before the pin mux and the processor handshake.
module muxbus_bridge_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ale,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic [DATA_W-1:0] bus_ad_o,
    input logic              bus_ad_oe,
    input logic              cpu_ready
);

    // R6: the two strobes are never active together.
    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R2: the ALE cycle drives the address and keeps both strobes high.
    assert_ale_drives_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_ad_oe && bus_rd_n && bus_wr_n));

    // R3: after ALE falls, the low address stays on AD for one more cycle.
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ale) |-> (bus_ad_oe && (bus_ad_o == $past(bus_ad_o)) && bus_rd_n && bus_wr_n));

    // R4: write data is already on AD, unchanged, when WR goes low.
    assert_wr_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) |-> (bus_ad_oe && $stable(bus_ad_o)));

    // R4: the write strobe lasts one cycle.
    assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |=> bus_wr_n);

    // R5: AD is released while the read strobe is low.
    assert_rd_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe);

    // R11: ready is a single-cycle pulse with the bus quiet.
    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_ready_bus_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (bus_rd_n && bus_wr_n && !bus_ale));

endmodule

bind muxbus_bridge muxbus_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_ale  (bus_ale),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_ad_o (bus_ad_o),
    .bus_ad_oe(bus_ad_oe),
    .cpu_ready(cpu_ready)
);

// File: tb/muxbus_bridge_bench.sv
// Sweep bench for the bridge: external memory and latch model, per-cycle pin
// checks and read-back against arithmetic expectations.
module muxbus_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic [7:0]  gpio_ad_out = 8'hC3;
    logic [7:0]  gpio_ad_oe = 8'h0F;
    logic [7:0]  gpio_hi_out = 8'h96;
    logic [7:0]  gpio_hi_oe = 8'hF0;
    logic [2:0]  gpio_ctl_out = 3'b110;
    logic [2:0]  gpio_ctl_oe = 3'b010;
    logic [7:0]  pad_ad_o, pad_ad_oe, pad_ad_i, pad_hi_o, pad_hi_oe;
    logic        pad_ale, pad_rd_n, pad_wr_n;
    logic [2:0]  pad_ctl_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] ext_mem    [65536];
    logic [7:0] ext_shadow [65536];
    logic [7:0] int_exp    [256];
    logic [7:0] lat_lo = '0;

    always #10 clk = ~clk;

    muxbus_bridge u_muxbus_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .gpio_ad_out(gpio_ad_out), .gpio_ad_oe(gpio_ad_oe),
        .gpio_hi_out(gpio_hi_out), .gpio_hi_oe(gpio_hi_oe),
        .gpio_ctl_out(gpio_ctl_out), .gpio_ctl_oe(gpio_ctl_oe),
        .pad_ad_o(pad_ad_o), .pad_ad_oe(pad_ad_oe), .pad_ad_i(pad_ad_i),
        .pad_hi_o(pad_hi_o), .pad_hi_oe(pad_hi_oe),
        .pad_ale(pad_ale), .pad_rd_n(pad_rd_n), .pad_wr_n(pad_wr_n),
        .pad_ctl_oe(pad_ctl_oe)
    );

    // External latch and memory model, sampled mid-cycle.
    always @(negedge clk) begin
        if (pad_ale) lat_lo <= pad_ad_o;
        if (!pad_wr_n) ext_mem[{pad_hi_o, lat_lo}] <= pad_ad_o;
    end
    assign pad_ad_i = !pad_rd_n ? ext_mem[{pad_hi_o, lat_lo}] : 8'hEE;

    function automatic logic [7:0] init_pat(input int i);
        return 8'(i) ^ 8'(i >> 8) ^ 8'h3C;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pins_now();
        return {pad_ad_o, pad_ad_oe, pad_hi_o, pad_hi_oe, pad_ale, pad_rd_n, pad_wr_n, pad_ctl_oe};
    endfunction

    function automatic logic [63:0] gpio_now();
        return {gpio_ad_out, gpio_ad_oe, gpio_hi_out, gpio_hi_oe,
                gpio_ctl_out[0], gpio_ctl_out[1], gpio_ctl_out[2], gpio_ctl_oe};
    endfunction

    // One access with per-cycle pin checks; flip toggles cfg_en mid-access (R9).
    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d, input logic flip);
        logic m, ext;
        logic [7:0] exp_rd;
        @(negedge clk);
        m = cfg_en;
        ext = (a > 16'h00FF);
        if (m) chk("R8 idle pins owned", {pad_ale, pad_rd_n, pad_wr_n, pad_ad_oe, pad_hi_oe, pad_ctl_oe},
                   {1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 3'b111});
        else   chk("R8 idle pins follow gpio", pins_now(), gpio_now());
        exp_rd = ext ? (m ? ext_shadow[a] : 8'h00) : int_exp[a[7:0]];
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (m) begin
            @(negedge clk);
            chk("R2 ale cycle", {pad_ale, pad_rd_n, pad_wr_n, pad_ad_oe, pad_ad_o, pad_hi_o, pad_hi_oe},
                {1'b1, 1'b1, 1'b1, 8'hFF, a[7:0], a[15:8], 8'hFF});
            chk("R11 not ready c1", cpu_ready, 0);
            @(negedge clk);
            chk("R3 address hold", {pad_ale, pad_rd_n, pad_wr_n, pad_ad_oe, pad_ad_o},
                {1'b0, 1'b1, 1'b1, 8'hFF, a[7:0]});
            if (flip) begin
                cfg_en = ~cfg_en;
                gpio_ad_out = ~gpio_ad_out; gpio_ctl_out = 3'b000; gpio_hi_oe = ~gpio_hi_oe;
                #1 chk("R9 R8 gpio ignored mid-access", {pad_ale, pad_rd_n, pad_wr_n, pad_ad_o, pad_hi_oe, pad_ctl_oe},
                       {1'b0, 1'b1, 1'b1, a[7:0], 8'hFF, 3'b111});
            end
            @(negedge clk);
            if (we)       chk("R4 data before WR", {pad_ad_oe, pad_ad_o, pad_rd_n, pad_wr_n}, {8'hFF, d, 2'b11});
            else if (ext) chk("R5 released before RD", {pad_ad_oe, pad_rd_n, pad_wr_n}, {8'h00, 2'b11});
            else          chk("R7 internal read data driven", {pad_ad_oe, pad_ad_o, pad_rd_n, pad_wr_n},
                              {8'hFF, int_exp[a[7:0]], 2'b11});
            chk("R3 ale stays low c3", pad_ale, 0);
            @(negedge clk);
            if (ext && we)  chk("R4 R1 WR strobe", {pad_ad_oe, pad_ad_o, pad_rd_n, pad_wr_n}, {8'hFF, d, 2'b10});
            else if (ext)   chk("R5 R1 RD strobe", {pad_ad_oe, pad_rd_n, pad_wr_n}, {8'h00, 2'b01});
            else            chk("R7 R1 no strobe internal", {pad_rd_n, pad_wr_n}, 2'b11);
            chk("R6 R3 ale low c4", pad_ale, 0);
            chk("R11 not ready c4", cpu_ready, 0);
            @(negedge clk);
            chk("R11 ready c5", cpu_ready, 1);
            chk("R6 strobes idle c5", {pad_rd_n, pad_wr_n, pad_ale}, 3'b110);
            if (!we) chk(ext ? "R5 external read data" : "R7 internal read data", cpu_rdata, exp_rd);
            if (we && ext) ext_shadow[a] = d;
        end else begin
            @(negedge clk);
            chk("R8 disabled pins", pins_now(), gpio_now());
            chk("R11 not ready local", cpu_ready, 0);
            if (flip) cfg_en = ~cfg_en;
            gpio_ad_out = gpio_ad_out + 8'h17; gpio_hi_oe = gpio_hi_oe ^ 8'h33;
            #1 chk("R8 disabled pins track gpio", pins_now(), gpio_now());
            @(negedge clk);
            chk("R11 ready local", cpu_ready, 1);
            if (!we) chk(ext ? "R10 unmapped read zero" : "R1 internal read disabled", cpu_rdata, exp_rd);
        end
        if (we && !ext) int_exp[a[7:0]] = d;
        cpu_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 65536; i++) begin
            ext_mem[i] = init_pat(i);
            ext_shadow[i] = init_pat(i);
        end
        cfg_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 reset ready", cpu_ready, 0);
        chk("R12 reset rdata", cpu_rdata, 0);
        chk("R12 reset pins gpio", pins_now(), gpio_now());
        rst_n = 1'b1;
        @(negedge clk);

        // Enabled sweep across the boundary.
        for (int a = 16'h00C0; a < 16'h0140; a++) access(1'b1, 16'(a), 8'(a) ^ 8'hA5, 1'b0);
        for (int a = 16'h00C0; a < 16'h0140; a++) access(1'b0, 16'(a), 8'h00, 1'b0);

        // High-byte sweep.
        for (int h = 0; h < 256; h++) access(1'b1, {8'(h), ~8'(h)}, 8'(h) ^ 8'h69, 1'b0);
        for (int h = 0; h < 256; h++) access(1'b0, {8'(h), ~8'(h)}, 8'h00, 1'b0);
        for (int h = 1; h < 256; h += 16) access(1'b0, {8'(h), 8'(h)}, 8'h00, 1'b0);

        // Disabled mode: internal path and unmapped addresses.
        cfg_en = 1'b0;
        for (int a = 16'h00F0; a < 16'h0110; a++) access(1'b1, 16'(a), 8'(a) ^ 8'h5A, 1'b0);
        for (int a = 16'h01F0; a < 16'h0200; a++) access(1'b1, 16'(a), 8'h77, 1'b0);
        for (int a = 16'h00F0; a < 16'h0110; a++) access(1'b0, 16'(a), 8'h00, 1'b0);

        // Back to enabled: no alias (R10) in internal RAM or external memory.
        cfg_en = 1'b1;
        for (int a = 16'h00F0; a < 16'h0100; a++) access(1'b0, 16'(a), 8'h00, 1'b0);
        for (int a = 16'h01F0; a < 16'h0200; a++) access(1'b0, 16'(a), 8'h00, 1'b0);

        // Enable flips during accesses (R9).
        for (int k = 0; k < 8; k++) begin
            access(k[0], 16'h0100 + 16'(k * 37), 8'(k) ^ 8'hE1, 1'b1);
            access(1'b0, 16'h00F0 + 16'(k), 8'h00, 1'b1);
        end
        cfg_en = 1'b1;
        for (int k = 0; k < 8; k++) access(1'b0, 16'h0100 + 16'(k * 37), 8'h00, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule